// File: doc/BRIEF.md
# Timestamp Record Queue

This block sits between an event-message detector running on the network clock and a processor that polls for timestamps. When the detector flags a timing event message, the block takes the current seconds and nanoseconds together with the message type, checksum and sequence number, all from that same clock edge. It packs them into a fixed 128-bit record and pushes the record into a dual-clock queue of 16 entries.

On the processor clock, software raises a request. The block then presents the oldest record with a valid flag, and removes it from the queue when software acknowledges. If a capture arrives while the queue is full, the record is discarded and a sticky overflow flag is raised; software clears it with a pulse. One instance serves each traffic direction.

Top module: `ts_record_queue`

## Requirements
- R1: A record is laid out, from bit 127 down to bit 0, as: [127:112] zero, [111:64] seconds, [63:32] nanoseconds, [31:28] message type, [27:16] checksum, [15:0] sequence number.
- R2: All fields of a record are taken from the inputs on the net_clk edge where cap_stb is high, and not from any other edge.
- R3: Records are read out in the order they were captured, and the queue holds 16 records.
- R4: A capture that arrives while the queue holds 16 unread records is dropped and leaves the stored records unchanged.
- R5: A dropped capture sets ovf_flag, which stays high until a one-cycle ovf_clr pulse on cpu_clk clears it.
- R6: rd_valid rises only while rd_req is high and the queue is non-empty, and rd_data stays stable while rd_valid is high and rd_ack is low.
- R7: rd_ack while rd_valid is high removes the presented record and drops rd_valid on the next cpu_clk edge.
- R8: After reset q_empty is 1, rd_valid is 0 and ovf_flag is 0, and q_empty is 0 whenever an unacknowledged record remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| net_clk | input | 1 | Network-side clock |
| net_rst_n | input | 1 | Active-low reset, network side |
| cap_stb | input | 1 | Event message detected, capture now |
| cap_msg_type | input | 4 | Message type field |
| cap_checksum | input | 12 | Checksum field |
| cap_seq_id | input | 16 | Sequence number field |
| time_sec | input | 48 | Current time, seconds |
| time_ns | input | 32 | Current time, nanoseconds |
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Active-low reset, processor side |
| rd_req | input | 1 | Software asks for the next record |
| rd_ack | input | 1 | Software has taken the presented record |
| rd_valid | output | 1 | rd_data holds a record |
| rd_data | output | 128 | Presented record |
| q_empty | output | 1 | No unread record in the queue |
| ovf_flag | output | 1 | Sticky: a capture was dropped |
| ovf_clr | input | 1 | One-cycle pulse that clears ovf_flag |

## Verification
A captured record reaches the processor side after the write pointer crosses a two-stage synchronizer. rd_valid then follows one cpu_clk edge after the request, so the bench polls rd_valid at falling edges with a bounded wait rather than at a fixed cycle. A pop is due exactly one cpu_clk edge after the acknowledge, and the bench samples rd_valid at the next falling edge. Overflow set and clear cross domains through two synchronizers each, so the bench allows ten cpu_clk cycles before sampling ovf_flag, and fills the queue only after the read pointer has settled on the network side.

// File: rtl/ts_record_queue.sv
module ts_record_queue #(
  parameter int ADDR_W = 4,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int MSG_W  = 4,
  parameter int CSUM_W = 12,
  parameter int SEQ_W  = 16,
  parameter int REC_W  = 128
) (
  input  logic              net_clk,
  input  logic              net_rst_n,
  input  logic              cap_stb,
  input  logic [MSG_W-1:0]  cap_msg_type,
  input  logic [CSUM_W-1:0] cap_checksum,
  input  logic [SEQ_W-1:0]  cap_seq_id,
  input  logic [SEC_W-1:0]  time_sec,
  input  logic [NS_W-1:0]   time_ns,
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic              rd_req,
  input  logic              rd_ack,
  output logic              rd_valid,
  output logic [REC_W-1:0]  rd_data,
  output logic              q_empty,
  output logic              ovf_flag,
  input  logic              ovf_clr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = REC_W - SEC_W - NS_W - MSG_W - CSUM_W - SEQ_W;

  function automatic logic [ADDR_W:0] to_gray(input logic [ADDR_W:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [REC_W-1:0] mem [DEPTH];

  // network side
  logic [ADDR_W:0] wbin, wgray, rq1, rq2;
  logic            full, ovf_net;
  logic [2:0]      clr_s;
  wire             clr_edge = clr_s[2] ^ clr_s[1];
  wire [REC_W-1:0] rec = {{PAD_W{1'b0}}, time_sec, time_ns, cap_msg_type, cap_checksum, cap_seq_id};

  assign wgray = to_gray(wbin);
  assign full  = wgray == {~rq2[ADDR_W:ADDR_W-1], rq2[ADDR_W-2:0]};

  always_ff @(posedge net_clk) begin
    if (cap_stb && !full) mem[wbin[ADDR_W-1:0]] <= rec;
  end

  logic [ADDR_W:0] rgray;

  always_ff @(posedge net_clk or negedge net_rst_n) begin
    if (!net_rst_n) begin
      wbin    <= '0;
      rq1     <= '0;
      rq2     <= '0;
      clr_s   <= '0;
      ovf_net <= 1'b0;
    end else begin
      rq1     <= rgray;
      rq2     <= rq1;
      clr_s   <= {clr_s[1:0], 1'b0} | {2'b00, 1'b0};
      clr_s[0] <= clr_tgl;
      ovf_net <= (cap_stb && full) || (ovf_net && !clr_edge);
      if (cap_stb && !full) wbin <= wbin + 1'b1;
    end
  end

  // processor side
  logic [ADDR_W:0] rbin, wq1, wq2;
  logic            os1, os2, clr_tgl;

  assign rgray    = to_gray(rbin);
  assign q_empty  = rgray == wq2;
  assign ovf_flag = os2;

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      rbin     <= '0;
      wq1      <= '0;
      wq2      <= '0;
      os1      <= 1'b0;
      os2      <= 1'b0;
      clr_tgl  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      os1 <= ovf_net;
      os2 <= os1;
      if (ovf_clr) clr_tgl <= ~clr_tgl;
      if (rd_valid && rd_ack) begin
        rd_valid <= 1'b0;
        rbin     <= rbin + 1'b1;
      end else if (!rd_valid && rd_req && !q_empty) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[rbin[ADDR_W-1:0]];
      end
    end
  end

  p_no_write_when_full_r4: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    full && cap_stb |=> $stable(wbin));
  p_drop_sets_flag_r5: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    full && cap_stb |=> ovf_net);
  p_valid_needs_req_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !rd_valid && !rd_req |=> !rd_valid);
  p_data_held_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    rd_valid && !rd_ack |=> rd_valid && $stable(rd_data));
  p_pop_drops_valid_r7: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    rd_valid && rd_ack |=> !rd_valid && rbin == $past(rbin) + 1'b1);
  p_valid_not_empty_r8: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    rd_valid |-> !q_empty);
  p_zero_pad_r1: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    rd_valid |-> rd_data[REC_W-1 -: PAD_W] == '0);
endmodule

// File: tb/ts_record_queue_test.sv
`timescale 1ns/1ps
module ts_record_queue_test;
  logic net_clk = 0, cpu_clk = 0, net_rst_n = 0, cpu_rst_n = 0;
  logic cap_stb = 0, rd_req = 0, rd_ack = 0, ovf_clr = 0;
  logic [3:0] cap_msg_type = 0;
  logic [11:0] cap_checksum = 0;
  logic [15:0] cap_seq_id = 0;
  logic [47:0] time_sec = 0;
  logic [31:0] time_ns = 0;
  logic rd_valid, q_empty, ovf_flag;
  logic [127:0] rd_data;

  always #2 net_clk = ~net_clk;
  always #5 cpu_clk = ~cpu_clk;

  ts_record_queue uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [127:0] expq[$];

  function automatic logic [127:0] pack(input logic [47:0] s, input logic [31:0] n,
      input logic [3:0] m, input logic [11:0] c, input logic [15:0] q);
    return {16'h0, s, n, m, c, q};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [47:0] s, input logic [31:0] n,
      input logic [3:0] m, input logic [11:0] c, input logic [15:0] q, input bit keep);
    @(negedge net_clk);
    cap_stb = 1; time_sec = s; time_ns = n; cap_msg_type = m; cap_checksum = c; cap_seq_id = q;
    if (keep) expq.push_back(pack(s, n, m, c, q));
    @(negedge net_clk);
    cap_stb = 0; time_sec = ~s; time_ns = ~n; cap_msg_type = ~m; cap_checksum = ~c; cap_seq_id = ~q;
  endtask

  task automatic read_one(input bit hold, input string req);
    bit got = 0;
    logic [127:0] d, e;
    @(negedge cpu_clk) rd_req = 1;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge cpu_clk);
      if (rd_valid) got = 1;
    end
    e = expq.size() ? expq.pop_front() : '0;
    d = rd_data;
    chk(got, "R6 valid after request", {127'h0, got}, 128'h1);
    chk(d === e, req, d, e);
    if (hold) begin
      repeat (3) @(negedge cpu_clk);
      chk(rd_valid && rd_data === d, "R6 data held without ack", rd_data, d);
    end
    rd_ack = 1;
    @(negedge cpu_clk);
    rd_ack = 0; rd_req = 0;
    chk(!rd_valid, "R7 valid drops after ack", {127'h0, rd_valid}, 128'h0);
  endtask

  initial begin
    repeat (4) @(negedge cpu_clk);
    net_rst_n = 1; cpu_rst_n = 1;
    @(negedge cpu_clk);
    chk(q_empty && !rd_valid && !ovf_flag, "R8 reset state", {125'h0, q_empty, rd_valid, ovf_flag}, 128'h4);

    // R1 layout with distinct field patterns
    capture(48'hA1B2_C3D4_E5F6, 32'h1234_5678, 4'hB, 12'h9C3, 16'hBEEF, 1);
    repeat (10) @(negedge cpu_clk);
    chk(!q_empty && !rd_valid, "R6 no presentation without request; R8 not empty", {126'h0, q_empty, rd_valid}, 128'h0);
    read_one(1, "R1 record layout");
    // R2 fields sampled on strobe edge (inputs change right after)
    capture(48'h0000_0000_0001, 32'hFFFF_FFFF, 4'h0, 12'hFFF, 16'h0000, 1);
    read_one(0, "R2 same-edge sampling");
    // ack without valid ignored
    @(negedge cpu_clk) rd_ack = 1;
    @(negedge cpu_clk) rd_ack = 0;
    chk(q_empty, "R7 stray ack ignored", {127'h0, q_empty}, 128'h1);

    // random bursts, order check (R3)
    void'($urandom(32'd1588));
    for (int it = 0; it < 40; it++) begin
      int n = 1 + $urandom_range(0, 4);
      for (int k = 0; k < n; k++)
        capture({$urandom, $urandom}, $urandom, $urandom, $urandom, $urandom, 1);
      for (int k = 0; k < n; k++) read_one(k == 0, "R3 capture order");
    end
    repeat (10) @(negedge cpu_clk);

    // fill to 16, 17th dropped (R4, R5)
    for (int k = 0; k < 16; k++)
      capture({16'h0, k[31:0]}, 32'h100 + k, k[3:0], 12'h0A5, 16'h7000 + k, 1);
    chk(!ovf_flag, "R5 no overflow at 16 entries", {127'h0, ovf_flag}, 128'h0);
    capture(48'hDEAD, 32'hDEAD, 4'hD, 12'hDAD, 16'hDEAD, 0);
    repeat (10) @(negedge cpu_clk);
    chk(ovf_flag, "R5 overflow flag set", {127'h0, ovf_flag}, 128'h1);
    for (int k = 0; k < 16; k++) read_one(0, "R4 stored records kept after drop");
    repeat (10) @(negedge cpu_clk);
    chk(q_empty, "R3 queue drained after 16 reads", {127'h0, q_empty}, 128'h1);
    chk(ovf_flag, "R5 flag sticky", {127'h0, ovf_flag}, 128'h1);
    @(negedge cpu_clk) ovf_clr = 1;
    @(negedge cpu_clk) ovf_clr = 0;
    repeat (10) @(negedge cpu_clk);
    chk(!ovf_flag, "R5 flag cleared", {127'h0, ovf_flag}, 128'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule